// File: doc/BRIEF.md
# Sixteen-Line GPIO Bank with Edge Interrupts

This block drives and samples sixteen general-purpose pins through a small memory-mapped register window. Software programs the output value and the direction of each pin. Separate set and clear addresses let it change single output bits or single interrupt-enable bits without a read-modify-write. Each input passes through a two-stage synchroniser. The synchronised level can be read back, and it also feeds a per-pin edge detector.

Every pin has a two-bit edge mode. A qualifying edge latches that pin's bit in a status register, whether or not its interrupt is enabled. Software clears status bits by writing ones. One interrupt output combines every status bit that is also enabled. Reads are combinational from the address. Writes take effect at the next rising clock edge.

Top module: `gpb_top`

## Requirements
- R1: After synchronous reset the output register is 0, every pin is an input (`pin_oe` all 0), the interrupt enables, the status bits and both edge-mode registers are 0, and `irq` is 0.
- R2: Reading offset 0x00 returns the major version in bits 7:4 and the minor version in bits 3:0, taken from parameters (default 0x21). Writes to that offset change nothing.
- R3: Offset 0x2C returns the pin inputs after a two-flop synchroniser. A pin change driven before rising edge k is readable once edge k+1 has passed, and not before.
- R4: Offset 0x30 holds the output value, which appears on `pin_out`. Offset 0x34 holds the direction, where 1 means input, and `pin_oe` is its bitwise inverse.
- R5: Writing to 0xF0 sets, and writing to 0xB0 clears, exactly the output bits that are 1 in the write data. Bits written as 0 keep their value.
- R6: Offset 0x1C holds the interrupt enables. Writing to 0xDC sets, and writing to 0x9C clears, only the enable bits written as 1.
- R7: Pin p has its edge mode at bits (p mod 8)*2+1:(p mod 8)*2, in offset 0x38 for pins 0 to 7 and in offset 0x3C for pins 8 to 15. The encoding is 00 none, 01 falling, 10 rising and 11 both edges.
- R8: A qualifying edge latches the pin's status bit at offset 0x18 even when its enable bit is 0. A pin in mode 00 never sets its status bit.
- R9: Writing a 1 to a bit of offset 0x18 clears that status bit. Bits written as 0 are left as they are.
- R10: If a new edge on a pin is detected in the same cycle as a write-one-to-clear of its status bit, the bit stays set.
- R11: `irq` is 1 exactly when some pin has both its status bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data; the low 16 bits are used |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Output values for the pins |
| pin_oe | output | 16 | Output enables, 1 = pin driven |
| irq | output | 1 | Combined interrupt |

## Verification
A software write-one-to-clear and a freshly detected edge can both target the same status bit in one cycle. The bench first sets a status bit and leaves it pending. It then toggles that pin, a both-edges pin, so that the detector fires on the same rising edge that applies a clear write to the bit. The bit must read back as still set, and a later clear with no edge present must remove it. Alias writes that carry mixed zero and one bits are checked the same way, by reading back the whole target register.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam logic [7:0] OFF_REV     = 8'h00;
    localparam logic [7:0] OFF_STS     = 8'h18;
    localparam logic [7:0] OFF_EN      = 8'h1C;
    localparam logic [7:0] OFF_DIN     = 8'h2C;
    localparam logic [7:0] OFF_DOUT    = 8'h30;
    localparam logic [7:0] OFF_DIR     = 8'h34;
    localparam logic [7:0] OFF_EDGE_LO = 8'h38;
    localparam logic [7:0] OFF_EDGE_HI = 8'h3C;
    localparam logic [7:0] OFF_EN_CLR  = 8'h9C;
    localparam logic [7:0] OFF_DO_CLR  = 8'hB0;
    localparam logic [7:0] OFF_EN_SET  = 8'hDC;
    localparam logic [7:0] OFF_DO_SET  = 8'hF0;

    typedef enum logic [1:0] {
        EM_NONE = 2'b00,
        EM_FALL = 2'b01,
        EM_RISE = 2'b10,
        EM_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic dout_wr;
        logic dout_set;
        logic dout_clr;
        logic dir_wr;
        logic en_wr;
        logic en_set;
        logic en_clr;
        logic sts_clr;
        logic edge_lo_wr;
        logic edge_hi_wr;
    } wr_strobe_t;

    function automatic logic edge_hit(edge_mode_e mode, logic prev, logic cur);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = prev & ~cur;
        case (mode)
            EM_FALL: edge_hit = fall;
            EM_RISE: edge_hit = rise;
            EM_BOTH: edge_hit = rise | fall;
            default: edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpb_decode.sv
module gpb_decode
    import gpb_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    output wr_strobe_t    strobe
);
    logic wr_any;
    assign wr_any = bus_sel & bus_wr;

    always_comb begin
        strobe            = '0;
        strobe.dout_wr    = wr_any && (bus_addr == AW'(OFF_DOUT));
        strobe.dout_set   = wr_any && (bus_addr == AW'(OFF_DO_SET));
        strobe.dout_clr   = wr_any && (bus_addr == AW'(OFF_DO_CLR));
        strobe.dir_wr     = wr_any && (bus_addr == AW'(OFF_DIR));
        strobe.en_wr      = wr_any && (bus_addr == AW'(OFF_EN));
        strobe.en_set     = wr_any && (bus_addr == AW'(OFF_EN_SET));
        strobe.en_clr     = wr_any && (bus_addr == AW'(OFF_EN_CLR));
        strobe.sts_clr    = wr_any && (bus_addr == AW'(OFF_STS));
        strobe.edge_lo_wr = wr_any && (bus_addr == AW'(OFF_EDGE_LO));
        strobe.edge_hi_wr = wr_any && (bus_addr == AW'(OFF_EDGE_HI));
    end
endmodule

// File: rtl/gpb_pin_event.sv
module gpb_pin_event
    import gpb_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPINS-1:0]   pin_in,
    input  logic [2*NPINS-1:0] edge_cfg,
    output logic [NPINS-1:0]   level,
    output logic [NPINS-1:0]   hit
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_in[p];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign level[p] = sync_q;
        assign hit[p]   = edge_hit(edge_mode_e'(edge_cfg[2*p +: 2]), prev_q, sync_q);
    end
endmodule

// File: rtl/gpb_irq_ctrl.sv
module gpb_irq_ctrl
    import gpb_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_strobe_t       strobe,
    input  logic [NPINS-1:0] wd,
    input  logic [NPINS-1:0] hit,
    output logic [NPINS-1:0] en_q,
    output logic [NPINS-1:0] sts_q,
    output logic             irq
);
    logic [NPINS-1:0] en_n;
    logic [NPINS-1:0] clr_mask;

    always_comb begin
        en_n = en_q;
        if (strobe.en_wr)
            en_n = wd;
        else if (strobe.en_set)
            en_n = en_q | wd;
        else if (strobe.en_clr)
            en_n = en_q & ~wd;
    end

    assign clr_mask = strobe.sts_clr ? wd : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            sts_q <= '0;
        end else begin
            en_q  <= en_n;
            sts_q <= (sts_q & ~clr_mask) | hit;
        end
    end

    assign irq = |(sts_q & en_q);
endmodule

// File: rtl/gpb_top.sv
module gpb_top
    import gpb_pkg::*;
#(
    parameter int         NPINS     = 16,
    parameter int         AW        = 8,
    parameter int         DW        = 32,
    parameter logic [3:0] REV_MAJOR = 4'h2,
    parameter logic [3:0] REV_MINOR = 4'h1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);
    localparam int EDGE_W = 2 * NPINS;
    localparam int HALF_W = EDGE_W / 2;

    wr_strobe_t       strobe;
    logic [NPINS-1:0] wd;
    logic             unused_wd_hi;
    logic [NPINS-1:0] dout_q;
    logic [NPINS-1:0] dir_q;
    logic [EDGE_W-1:0] edge_q;
    logic [NPINS-1:0] pin_level;
    logic [NPINS-1:0] pin_hit;
    logic [NPINS-1:0] irq_en;
    logic [NPINS-1:0] irq_sts;

    assign wd           = bus_wdata[NPINS-1:0];
    assign unused_wd_hi = ^bus_wdata[DW-1:NPINS];

    gpb_decode #(.AW(AW)) u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .strobe  (strobe)
    );

    gpb_pin_event #(.NPINS(NPINS)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .pin_in  (pin_in),
        .edge_cfg(edge_q),
        .level   (pin_level),
        .hit     (pin_hit)
    );

    gpb_irq_ctrl #(.NPINS(NPINS)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .strobe(strobe),
        .wd    (wd),
        .hit   (pin_hit),
        .en_q  (irq_en),
        .sts_q (irq_sts),
        .irq   (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            dir_q  <= '1;
            edge_q <= '0;
        end else begin
            if (strobe.dout_wr)
                dout_q <= wd;
            else if (strobe.dout_set)
                dout_q <= dout_q | wd;
            else if (strobe.dout_clr)
                dout_q <= dout_q & ~wd;
            if (strobe.dir_wr)
                dir_q <= wd;
            if (strobe.edge_lo_wr)
                edge_q[HALF_W-1:0] <= bus_wdata[HALF_W-1:0];
            if (strobe.edge_hi_wr)
                edge_q[EDGE_W-1:HALF_W] <= bus_wdata[HALF_W-1:0];
        end
    end

    assign pin_out = dout_q;
    assign pin_oe  = ~dir_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                AW'(OFF_REV):     bus_rdata = DW'({REV_MAJOR, REV_MINOR});
                AW'(OFF_STS):     bus_rdata = DW'(irq_sts);
                AW'(OFF_EN):      bus_rdata = DW'(irq_en);
                AW'(OFF_DIN):     bus_rdata = DW'(pin_level);
                AW'(OFF_DOUT):    bus_rdata = DW'(dout_q);
                AW'(OFF_DIR):     bus_rdata = DW'(dir_q);
                AW'(OFF_EDGE_LO): bus_rdata = DW'(edge_q[HALF_W-1:0]);
                AW'(OFF_EDGE_HI): bus_rdata = DW'(edge_q[EDGE_W-1:HALF_W]);
                default:          bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker
    import gpb_pkg::*;
#(
    parameter int         NPINS     = 16,
    parameter int         AW        = 8,
    parameter int         DW        = 32,
    parameter logic [3:0] REV_MAJOR = 4'h2,
    parameter logic [3:0] REV_MINOR = 4'h1
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [AW-1:0]      bus_addr,
    input logic [NPINS-1:0]   wd,
    input logic [DW-1:0]      bus_rdata,
    input logic [NPINS-1:0]   pin_oe,
    input logic [NPINS-1:0]   sts,
    input logic [NPINS-1:0]   en,
    input logic [NPINS-1:0]   dout,
    input logic [2*NPINS-1:0] edge_cfg,
    input logic [NPINS-1:0]   hit
);
    logic [NPINS-1:0] armed;
    logic [NPINS-1:0] clr_mask;
    logic             wr_any;

    always_comb begin
        for (int p = 0; p < NPINS; p++)
            armed[p] = |edge_cfg[2*p +: 2];
    end

    assign wr_any   = bus_sel && bus_wr;
    assign clr_mask = (wr_any && bus_addr == AW'(OFF_STS)) ? wd : '0;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sts == '0 && en == '0 && dout == '0 && edge_cfg == '0 && pin_oe == '0));

    assert_revision_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == AW'(OFF_REV)) |-> (bus_rdata[7:0] == {REV_MAJOR, REV_MINOR}));

    assert_set_alias_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_addr == AW'(OFF_DO_SET)) |=> ((dout & $past(wd)) == $past(wd)));

    assert_clr_enable_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_addr == AW'(OFF_EN_CLR)) |=> ((en & $past(wd)) == '0));

    assert_mode_none_R8: assert property (@(posedge clk) disable iff (rst)
        ((sts & ~$past(sts) & ~$past(armed)) == '0));

    assert_w1c_only_R9: assert property (@(posedge clk) disable iff (rst)
        (($past(sts) & ~sts & ~$past(clr_mask)) == '0));

    assert_edge_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (($past(hit) & ~sts) == '0));
endmodule

bind gpb_top gpb_checker #(
    .NPINS    (NPINS),
    .AW       (AW),
    .DW       (DW),
    .REV_MAJOR(REV_MAJOR),
    .REV_MINOR(REV_MINOR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wd       (wd),
    .bus_rdata(bus_rdata),
    .pin_oe   (pin_oe),
    .sts      (irq_sts),
    .en       (irq_en),
    .dout     (dout_q),
    .edge_cfg (edge_q),
    .hit      (pin_hit)
);

// File: tb/sim_gpb_top.sv
module sim_gpb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpb_top u0 (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .irq      (irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h30, v); check("R1 dout", v, 32'h0);
        rd(8'h34, v); check("R1 dir", v, 32'hFFFF);
        rd(8'h1C, v); check("R1 enable", v, 32'h0);
        rd(8'h18, v); check("R1 status", v, 32'h0);
        rd(8'h38, v); check("R1 edge lo", v, 32'h0);
        rd(8'h3C, v); check("R1 edge hi", v, 32'h0);
        check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_revision();
        logic [31:0] v;
        rd(8'h00, v); check("R2 revision", v, 32'h21);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R2 revision after write", v, 32'h21);
    endtask

    task automatic t_datain();
        logic [31:0] v;
        @(negedge clk); pin_in = 16'hA5C3;
        @(posedge clk);
        rd(8'h2C, v); check("R3 data-in one edge early", v, 32'h0);
        @(negedge clk); pin_in = 16'h0000;
        @(posedge clk); @(posedge clk);
        rd(8'h2C, v); check("R3 data-in zero", v, 32'h0);
        @(negedge clk); pin_in = 16'h5A3C;
        @(posedge clk); @(posedge clk);
        rd(8'h2C, v); check("R3 data-in after sync", v, 32'h5A3C);
        @(negedge clk); pin_in = 16'h0000;
        settle();
    endtask

    task automatic t_dout_dir();
        @(negedge clk);
        wr(8'h30, 32'hFFFF_1234);
        check("R4 pin_out", {16'h0, pin_out}, 32'h1234);
        wr(8'h34, 32'h00F0);
        check("R4 pin_oe", {16'h0, pin_oe}, 32'hFF0F);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(8'hF0, 32'h8001);
        rd(8'h30, v); check("R5 set alias", v, 32'h9235);
        wr(8'hB0, 32'h0204);
        rd(8'h30, v); check("R5 clear alias", v, 32'h9031);
        check("R5 pin_out", {16'h0, pin_out}, 32'h9031);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(8'h1C, 32'h00FF);
        rd(8'h1C, v); check("R6 enable write", v, 32'h00FF);
        wr(8'hDC, 32'h0100);
        rd(8'h1C, v); check("R6 enable set alias", v, 32'h01FF);
        wr(8'h9C, 32'h000F);
        rd(8'h1C, v); check("R6 enable clear alias", v, 32'h01F0);
        wr(8'h1C, 32'h0000);
    endtask

    task automatic t_edges();
        logic [31:0] v;
        @(negedge clk); pin_in = 16'h0002;
        settle();
        wr(8'h18, 32'hFFFF);
        rd(8'h18, v); check("R8 mode none leaves status", v, 32'h0);
        wr(8'h38, 32'h0036);
        wr(8'h3C, 32'hC008);
        rd(8'h38, v); check("R7 edge lo readback", v, 32'h0036);
        rd(8'h3C, v); check("R7 edge hi readback", v, 32'hC008);
        @(negedge clk); pin_in = 16'h820D;
        settle();
        rd(8'h18, v); check("R7 R8 status on mixed edges", v, 32'h8207);
        check("R11 irq with enables off", {31'h0, irq}, 32'h0);
        wr(8'h18, 32'hFFFF);
        rd(8'h18, v); check("R9 clear all", v, 32'h0);
        @(negedge clk); pin_in = 16'h8208;
        settle();
        rd(8'h18, v); check("R7 falling only on both-edge pin", v, 32'h0004);
    endtask

    task automatic t_w1c_irq();
        logic [31:0] v;
        wr(8'h18, 32'h0000);
        rd(8'h18, v); check("R9 zero bits ignored", v, 32'h0004);
        wr(8'h18, 32'h0003);
        rd(8'h18, v); check("R9 other bits ignored", v, 32'h0004);
        wr(8'hDC, 32'h0004);
        check("R11 irq raised", {31'h0, irq}, 32'h1);
        wr(8'h9C, 32'h0004);
        check("R11 irq masked", {31'h0, irq}, 32'h0);
        wr(8'h1C, 32'h0008);
        check("R11 irq other enable", {31'h0, irq}, 32'h0);
        wr(8'h1C, 32'h0000);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        rd(8'h18, v); check("R10 bit pending before", v, 32'h0004);
        @(negedge clk); pin_in = 16'h820C;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h0004;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(8'h18, v); check("R10 edge wins over clear", v, 32'h0004);
        settle();
        wr(8'h18, 32'h0004);
        rd(8'h18, v); check("R10 later clear works", v, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_revision();
        t_datain();
        t_dout_dir();
        t_alias();
        t_enable();
        t_edges();
        t_w1c_irq();
        t_collision();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule